// File: doc/BRIEF.md
# Receiver Error Hold and Interrupt Logic

This block sits behind the frame decoder of a digital audio receiver. Every decoded stereo frame arrives with a one-cycle strobe, a left and a right sample, and five per-frame error flags. An enable register selects which flags count. Only an enabled flag is recorded, raises the receiver-error interrupt source, or disturbs the audio path. When a counted error occurs, a two-bit hold selector chooses what leaves the block: the last error-free sample pair, a zeroed pair, or the received pair unchanged.

The block also watches the received samples for digital silence. It raises a flag after an exact run of all-zero frames and drops it on the first frame that carries data. Two interrupt sources feed a small interrupt unit: "the error register is non-zero" and "silence is present". Each source has an enable bit and a two-bit trigger code. The code is split across a high register and a low register that share the same bit position. Status bits are sticky until a read strobe, and the interrupt pin is high while any status bit is set.

Top module: `rx_err_guard`

## Requirements
- R1: With hold selector 00, a frame carrying any enabled error flag produces the most recent error-free sample pair on the outputs (zero if none has arrived since reset); error-free frames update that stored pair in every hold mode.
- R2: With hold selector 01, a frame carrying an enabled error flag produces zero on both sample outputs.
- R3: With hold selector 10, and with the reserved code 11, a frame carrying an enabled error flag passes the received pair through unchanged.
- R4: Error flag bit positions are 0 parity, 1 bi-phase coding, 2 confidence, 3 clock-recovery unlock, 4 validity. A flag raised on a frame whose `err_enable` bit is 1 sets the same bit of `err_reg` one cycle after the strobe.
- R5: A flag whose `err_enable` bit is 0 sets no `err_reg` bit, raises no interrupt through the error source, and leaves the received samples unaltered.
- R6: `err_reg` bits stay set until `err_rd` is pulsed.
- R7: `err_rd` clears `err_reg` on the following cycle, except for bits set by a frame strobed in that same cycle.
- R8: `silence` rises one cycle after the frame that completes a run of exactly SIL_RUN (default 1548) consecutive frames with both samples zero, and not one frame earlier.
- R9: The first frame with a non-zero sample clears `silence` on the next cycle.
- R10: Interrupt source 0 is "`err_reg` non-zero" and source 1 is `silence`. Trigger code {`irq_mode_hi`[i], `irq_mode_lo`[i]} selects the event: 00 rising edge, 01 falling edge, 10 while the source is high, 11 never. The source is sampled from registered state, so a status bit sets two cycles after the frame that changes the source.
- R11: An interrupt source whose `irq_enable` bit is 0 never sets its `irq_stat` bit and so never drives `irq`. `irq_rd` clears `irq_stat`, and `irq` is high exactly while `irq_stat` is non-zero.
- R12: After reset, all outputs are zero.
- R13: `out_vld` is high for exactly the cycle after each frame strobe. Sample outputs hold their value between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | Strobe marking a decoded frame |
| rx_left | input | W | Received left sample |
| rx_right | input | W | Received right sample |
| err_flags | input | 5 | Per-frame error flags (parity, bi-phase, confidence, unlock, validity) |
| err_enable | input | 5 | Per-flag enable; 1 counts the flag |
| hold_sel | input | 2 | Sample action on a counted error |
| err_rd | input | 1 | Read strobe clearing the error register |
| irq_enable | input | 2 | Per-source interrupt enable |
| irq_mode_hi | input | 2 | Upper bit of each source's trigger code |
| irq_mode_lo | input | 2 | Lower bit of each source's trigger code |
| irq_rd | input | 1 | Read strobe clearing interrupt status |
| out_vld | output | 1 | Conditioned sample pair valid |
| out_left | output | W | Conditioned left sample |
| out_right | output | W | Conditioned right sample |
| err_reg | output | 5 | Sticky error register |
| silence | output | 1 | Digital silence detected |
| irq_stat | output | 2 | Sticky interrupt status |
| irq | output | 1 | Interrupt pin, active high |

## Verification
The properties assume that the enable, hold and trigger registers are quasi-static and that frame strobes are single-cycle. They place no limit on how often strobes or read pulses arrive or on which cycles they fall, so random stimulus may strobe on every cycle and may pulse both read strobes alongside frames. The stimulus changes inputs only on the falling edge. It mixes directed sequences, such as a long zero run that reaches the silence boundary and the trigger code sequence, with random flags, enables and read pulses.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    localparam int NUM_ERR = 5;
    localparam int NUM_IRQ = 2;

    localparam int ERR_PARITY  = 0;
    localparam int ERR_BIPHASE = 1;
    localparam int ERR_CONF    = 2;
    localparam int ERR_UNLOCK  = 3;
    localparam int ERR_VALID   = 4;

    localparam int SRC_ERR     = 0;
    localparam int SRC_SILENCE = 1;

    typedef enum logic [1:0] {
        HOLD_LAST = 2'b00,
        HOLD_ZERO = 2'b01,
        HOLD_PASS = 2'b10,
        HOLD_RSVD = 2'b11
    } hold_mode_e;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_OFF   = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/rxg_err_reg.sv
module rxg_err_reg
    import rxg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld,
    input  logic [NUM_ERR-1:0] err_flags,
    input  logic [NUM_ERR-1:0] err_enable,
    input  logic               err_rd,
    output logic [NUM_ERR-1:0] err_reg,
    output logic               frame_bad
);

    typedef struct packed {
        logic [NUM_ERR-1:0] bits;
    } err_state_t;

    err_state_t st_d, st_q;
    logic [NUM_ERR-1:0] hits;

    always_comb begin
        hits = frame_vld ? (err_flags & err_enable) : '0;
        st_d = st_q;
        if (err_rd) begin
            st_d.bits = '0;
        end
        st_d.bits = st_d.bits | hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_reg   = st_q.bits;
    assign frame_bad = |hits;

endmodule

// File: rtl/rxg_sample_path.sv
module rxg_sample_path
    import rxg_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_vld,
    input  logic         frame_bad,
    input  logic [1:0]   hold_sel,
    input  logic [W-1:0] rx_left,
    input  logic [W-1:0] rx_right,
    output logic         out_vld,
    output logic [W-1:0] out_left,
    output logic [W-1:0] out_right
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] left;
        logic [W-1:0] right;
        logic [W-1:0] good_left;
        logic [W-1:0] good_right;
    } path_state_t;

    path_state_t st_d, st_q;
    hold_mode_e  mode;

    always_comb begin
        mode   = hold_mode_e'(hold_sel);
        st_d   = st_q;
        st_d.vld = frame_vld;
        if (frame_vld) begin
            if (!frame_bad) begin
                st_d.left       = rx_left;
                st_d.right      = rx_right;
                st_d.good_left  = rx_left;
                st_d.good_right = rx_right;
            end else begin
                unique case (mode)
                    HOLD_LAST: begin
                        st_d.left  = st_q.good_left;
                        st_d.right = st_q.good_right;
                    end
                    HOLD_ZERO: begin
                        st_d.left  = '0;
                        st_d.right = '0;
                    end
                    default: begin
                        st_d.left  = rx_left;
                        st_d.right = rx_right;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld   = st_q.vld;
    assign out_left  = st_q.left;
    assign out_right = st_q.right;

endmodule

// File: rtl/rxg_silence_det.sv
module rxg_silence_det #(
    parameter int W       = 24,
    parameter int SIL_RUN = 1548
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_vld,
    input  logic [W-1:0] rx_left,
    input  logic [W-1:0] rx_right,
    output logic         silence
);

    localparam int CW = $clog2(SIL_RUN + 1);
    localparam logic [CW-1:0] RUN_END = CW'(SIL_RUN);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          flag;
    } sil_state_t;

    sil_state_t st_d, st_q;
    logic       zero_frame;

    always_comb begin
        zero_frame = (rx_left == '0) && (rx_right == '0);
        st_d = st_q;
        if (frame_vld) begin
            if (zero_frame) begin
                if (st_q.run != RUN_END) begin
                    st_d.run = st_q.run + 1'b1;
                end
                st_d.flag = (st_d.run == RUN_END);
            end else begin
                st_d.run  = '0;
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign silence = st_q.flag;

endmodule

// File: rtl/rxg_irq_unit.sv
module rxg_irq_unit
    import rxg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] src,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [NUM_IRQ-1:0] irq_mode_hi,
    input  logic [NUM_IRQ-1:0] irq_mode_lo,
    input  logic               irq_rd,
    output logic [NUM_IRQ-1:0] irq_stat,
    output logic               irq
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] stat;
        logic [NUM_IRQ-1:0] prev;
    } irq_state_t;

    irq_state_t         st_d, st_q;
    logic [NUM_IRQ-1:0] event_hit;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        trig_mode_e code;
        always_comb begin
            code = trig_mode_e'({irq_mode_hi[i], irq_mode_lo[i]});
            unique case (code)
                TRIG_RISE:  event_hit[i] = src[i] & ~st_q.prev[i];
                TRIG_FALL:  event_hit[i] = ~src[i] & st_q.prev[i];
                TRIG_LEVEL: event_hit[i] = src[i];
                default:    event_hit[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = src;
        if (irq_rd) begin
            st_d.stat = '0;
        end
        st_d.stat = st_d.stat | (event_hit & irq_enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_stat = st_q.stat;
    assign irq      = |st_q.stat;

endmodule

// File: rtl/rx_err_guard.sv
module rx_err_guard
    import rxg_pkg::*;
#(
    parameter int W       = 24,
    parameter int SIL_RUN = 1548
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_vld,
    input  logic [W-1:0]       rx_left,
    input  logic [W-1:0]       rx_right,
    input  logic [NUM_ERR-1:0] err_flags,
    input  logic [NUM_ERR-1:0] err_enable,
    input  logic [1:0]         hold_sel,
    input  logic               err_rd,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [NUM_IRQ-1:0] irq_mode_hi,
    input  logic [NUM_IRQ-1:0] irq_mode_lo,
    input  logic               irq_rd,
    output logic               out_vld,
    output logic [W-1:0]       out_left,
    output logic [W-1:0]       out_right,
    output logic [NUM_ERR-1:0] err_reg,
    output logic               silence,
    output logic [NUM_IRQ-1:0] irq_stat,
    output logic               irq
);

    logic               frame_bad;
    logic [NUM_IRQ-1:0] irq_src;

    rxg_err_reg i_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .err_flags  (err_flags),
        .err_enable (err_enable),
        .err_rd     (err_rd),
        .err_reg    (err_reg),
        .frame_bad  (frame_bad)
    );

    rxg_sample_path #(.W(W)) i_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .frame_bad (frame_bad),
        .hold_sel  (hold_sel),
        .rx_left   (rx_left),
        .rx_right  (rx_right),
        .out_vld   (out_vld),
        .out_left  (out_left),
        .out_right (out_right)
    );

    rxg_silence_det #(.W(W), .SIL_RUN(SIL_RUN)) i_sil (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .rx_left   (rx_left),
        .rx_right  (rx_right),
        .silence   (silence)
    );

    always_comb begin
        irq_src              = '0;
        irq_src[SRC_ERR]     = |err_reg;
        irq_src[SRC_SILENCE] = silence;
    end

    rxg_irq_unit i_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (irq_src),
        .irq_enable  (irq_enable),
        .irq_mode_hi (irq_mode_hi),
        .irq_mode_lo (irq_mode_lo),
        .irq_rd      (irq_rd),
        .irq_stat    (irq_stat),
        .irq         (irq)
    );

endmodule

// File: rtl/rxg_checker.sv
module rxg_checker
    import rxg_pkg::*;
#(
    parameter int W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_vld,
    input logic [W-1:0]       rx_left,
    input logic [W-1:0]       rx_right,
    input logic [NUM_ERR-1:0] err_flags,
    input logic [NUM_ERR-1:0] err_enable,
    input logic [1:0]         hold_sel,
    input logic               err_rd,
    input logic [NUM_IRQ-1:0] irq_enable,
    input logic               irq_rd,
    input logic               out_vld,
    input logic [W-1:0]       out_left,
    input logic [W-1:0]       out_right,
    input logic [NUM_ERR-1:0] err_reg,
    input logic               silence,
    input logic [NUM_IRQ-1:0] irq_stat
);

    // R2: zero mode on a counted error
    a_r2_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && hold_sel == 2'b01 && (err_flags & err_enable) != '0)
        |=> (out_left == '0 && out_right == '0));

    // R3: pass mode forwards the received pair
    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && hold_sel == 2'b10)
        |=> (out_left == $past(rx_left) && out_right == $past(rx_right)));

    // R4: enabled flags land in the error register
    a_r4_flag_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld
        |=> ((err_reg & $past(err_flags & err_enable)) == $past(err_flags & err_enable)));

    // R5: frames without a counted error pass unaltered
    a_r5_clean_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && (err_flags & err_enable) == '0)
        |=> (out_left == $past(rx_left) && out_right == $past(rx_right)));

    // R6: bits are sticky without a read
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_rd && !frame_vld) |=> (err_reg == $past(err_reg)));

    // R7: read clears
    a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rd && !frame_vld) |=> (err_reg == '0));

    // R9: data ends silence
    a_r9_silence_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && (rx_left != '0 || rx_right != '0)) |=> !silence);

    // R11: disabled sources never set status
    a_r11_disabled_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rd |=> ((irq_stat & ~$past(irq_enable)) == '0));

    // R13: one valid pulse per strobe
    a_r13_out_vld: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> out_vld);
    a_r13_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> (!out_vld && $stable(out_left) && $stable(out_right)));

endmodule

bind rx_err_guard rxg_checker #(.W(W)) i_rxg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld  (frame_vld),
    .rx_left    (rx_left),
    .rx_right   (rx_right),
    .err_flags  (err_flags),
    .err_enable (err_enable),
    .hold_sel   (hold_sel),
    .err_rd     (err_rd),
    .irq_enable (irq_enable),
    .irq_rd     (irq_rd),
    .out_vld    (out_vld),
    .out_left   (out_left),
    .out_right  (out_right),
    .err_reg    (err_reg),
    .silence    (silence),
    .irq_stat   (irq_stat)
);

// File: tb/test_rx_err_guard.sv
module test_rx_err_guard;

    localparam int W       = 24;
    localparam int SIL_RUN = 1548;
    localparam int LIMIT   = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_vld = 1'b0;
    logic [W-1:0] rx_left = '0;
    logic [W-1:0] rx_right = '0;
    logic [4:0]   err_flags = '0;
    logic [4:0]   err_enable = '0;
    logic [1:0]   hold_sel = '0;
    logic         err_rd = 1'b0;
    logic [1:0]   irq_enable = '0;
    logic [1:0]   irq_mode_hi = '0;
    logic [1:0]   irq_mode_lo = '0;
    logic         irq_rd = 1'b0;

    logic         out_vld;
    logic [W-1:0] out_left;
    logic [W-1:0] out_right;
    logic [4:0]   err_reg;
    logic         silence;
    logic [1:0]   irq_stat;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_err_guard #(.W(W), .SIL_RUN(SIL_RUN)) i_rx_err_guard (
        .clk (clk), .rst_n (rst_n), .frame_vld (frame_vld),
        .rx_left (rx_left), .rx_right (rx_right),
        .err_flags (err_flags), .err_enable (err_enable),
        .hold_sel (hold_sel), .err_rd (err_rd),
        .irq_enable (irq_enable), .irq_mode_hi (irq_mode_hi),
        .irq_mode_lo (irq_mode_lo), .irq_rd (irq_rd),
        .out_vld (out_vld), .out_left (out_left), .out_right (out_right),
        .err_reg (err_reg), .silence (silence),
        .irq_stat (irq_stat), .irq (irq)
    );

    // behavioural reference model
    logic [W-1:0] m_left = '0, m_right = '0, m_gl = '0, m_gr = '0;
    logic         m_vld = 1'b0;
    logic [4:0]   m_err = '0;
    int           m_zrun = 0;
    logic         m_sil = 1'b0;
    logic [1:0]   m_stat = '0, m_prev = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = '0; m_right = '0; m_gl = '0; m_gr = '0; m_vld = 1'b0;
            m_err = '0; m_zrun = 0; m_sil = 1'b0; m_stat = '0; m_prev = '0;
        end else begin
            logic [1:0] src;
            logic [1:0] nstat;
            logic       bad;
            src   = {m_sil, (m_err != 0)};
            nstat = irq_rd ? 2'b00 : m_stat;
            for (int i = 0; i < 2; i++) begin
                logic ev;
                case ({irq_mode_hi[i], irq_mode_lo[i]})
                    2'b00:   ev = src[i] && !m_prev[i];
                    2'b01:   ev = !src[i] && m_prev[i];
                    2'b10:   ev = src[i];
                    default: ev = 1'b0;
                endcase
                if (ev && irq_enable[i]) nstat[i] = 1'b1;
            end
            m_stat = nstat;
            m_prev = src;
            if (err_rd) m_err = '0;
            m_vld = frame_vld;
            if (frame_vld) begin
                m_err = m_err | (err_flags & err_enable);
                bad = (err_flags & err_enable) != 0;
                if (!bad) begin
                    m_left = rx_left; m_right = rx_right;
                    m_gl = rx_left; m_gr = rx_right;
                end else if (hold_sel == 2'b00) begin
                    m_left = m_gl; m_right = m_gr;
                end else if (hold_sel == 2'b01) begin
                    m_left = '0; m_right = '0;
                end else begin
                    m_left = rx_left; m_right = rx_right;
                end
                if (rx_left == 0 && rx_right == 0) begin
                    if (m_zrun < SIL_RUN) m_zrun++;
                    m_sil = (m_zrun == SIL_RUN);
                end else begin
                    m_zrun = 0; m_sil = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R13 out_vld", 32'(out_vld), 32'(m_vld));
            chk("R1 out_left", 32'(out_left), 32'(m_left));
            chk("R1 out_right", 32'(out_right), 32'(m_right));
            chk("R6 err_reg", 32'(err_reg), 32'(m_err));
            chk("R8 silence", 32'(silence), 32'(m_sil));
            chk("R10 irq_stat", 32'(irq_stat), 32'(m_stat));
            chk("R11 irq", 32'(irq), 32'(m_stat != 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            n_fail++;
            $display("FAIL R13 watchdog expired: actual %0d expected <= %0d cycles", cyc, LIMIT);
            finish_run();
        end
    end

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] l, input logic [W-1:0] r, input logic [4:0] f);
        frame_vld = 1'b1; rx_left = l; rx_right = r; err_flags = f;
        @(negedge clk);
        frame_vld = 1'b0; err_flags = '0;
    endtask

    task automatic pulse_err_rd();
        err_rd = 1'b1; @(negedge clk); err_rd = 1'b0;
    endtask

    task automatic pulse_irq_rd();
        irq_rd = 1'b1; @(negedge clk); irq_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 out_vld", 32'(out_vld), 0);
        chk("R12 out_left", 32'(out_left), 0);
        chk("R12 err_reg", 32'(err_reg), 0);
        chk("R12 silence", 32'(silence), 0);
        chk("R12 irq", 32'(irq), 0);
        rst_n = 1'b1;
        idle();

        // R1: hold last good pair
        err_enable = 5'b11111; hold_sel = 2'b00;
        send(24'h000111, 24'h000222, 5'b00000);
        chk("R13 valid after strobe", 32'(out_vld), 1);
        send(24'h000333, 24'h000444, 5'b00001);
        chk("R1 held left", 32'(out_left), 32'h111);
        chk("R1 held right", 32'(out_right), 32'h222);
        chk("R4 parity bit", 32'(err_reg), 32'h01);
        idle();
        chk("R13 valid drops", 32'(out_vld), 0);
        chk("R6 still set", 32'(err_reg), 32'h01);
        pulse_err_rd();
        chk("R7 cleared", 32'(err_reg), 0);

        // R2: zero fill
        hold_sel = 2'b01;
        send(24'h0000AA, 24'h0000BB, 5'b00010);
        chk("R2 zero left", 32'(out_left), 0);
        chk("R4 bi-phase bit", 32'(err_reg), 32'h02);

        // R3: pass and reserved
        hold_sel = 2'b10;
        send(24'h123456, 24'h654321, 5'b10000);
        chk("R3 pass left", 32'(out_left), 32'h123456);
        hold_sel = 2'b11;
        send(24'h00ABCD, 24'h00DCBA, 5'b01000);
        chk("R3 reserved pass", 32'(out_right), 32'h00DCBA);
        pulse_err_rd();

        // R5: disabled flag ignored everywhere
        hold_sel = 2'b01; err_enable = 5'b10000;
        irq_enable = 2'b01; irq_mode_hi = 2'b00; irq_mode_lo = 2'b00;
        send(24'h000777, 24'h000888, 5'b00100);
        chk("R5 sample unaltered", 32'(out_left), 32'h777);
        chk("R5 no error bit", 32'(err_reg), 0);
        idle();
        chk("R5 no interrupt", 32'(irq), 0);

        // R10: rising edge event
        err_enable = 5'b11111;
        send(24'h000001, 24'h000001, 5'b00100);
        idle();
        chk("R10 rising event", 32'(irq_stat), 32'h1);
        pulse_irq_rd();
        chk("R11 status read clear", 32'(irq), 0);
        // falling edge event
        irq_mode_lo = 2'b01;
        pulse_err_rd();
        idle();
        chk("R10 falling event", 32'(irq_stat), 32'h1);
        pulse_irq_rd();
        // level event
        irq_mode_hi = 2'b01; irq_mode_lo = 2'b00;
        idle();
        chk("R10 level low source", 32'(irq), 0);
        send(24'h000002, 24'h000002, 5'b01000);
        idle();
        chk("R10 level event", 32'(irq), 1);
        // disabled source under level mode
        irq_enable = 2'b00;
        pulse_irq_rd();
        idle();
        chk("R11 disabled source", 32'(irq), 0);
        // code 11 never fires
        irq_enable = 2'b01; irq_mode_hi = 2'b01; irq_mode_lo = 2'b01;
        idle(); idle();
        chk("R10 code 11 silent", 32'(irq), 0);
        pulse_err_rd();

        // R8 / R9: silence boundary
        irq_enable = 2'b10; irq_mode_hi = 2'b00; irq_mode_lo = 2'b00;
        for (int k = 0; k < SIL_RUN - 1; k++) send('0, '0, 5'b00000);
        chk("R8 one short of run", 32'(silence), 0);
        send('0, '0, 5'b00000);
        chk("R8 run complete", 32'(silence), 1);
        idle();
        chk("R10 silence source", 32'(irq_stat), 32'h2);
        send('0, 24'h000010, 5'b00000);
        chk("R9 silence cleared", 32'(silence), 0);
        pulse_irq_rd();

        // random traffic against the model
        irq_enable = 2'b11;
        for (int k = 0; k < 3000; k++) begin
            frame_vld = ($urandom_range(0, 3) != 0);
            rx_left   = ($urandom_range(0, 3) == 0) ? '0 : W'($urandom);
            rx_right  = ($urandom_range(0, 3) == 0) ? '0 : W'($urandom);
            err_flags = ($urandom_range(0, 2) == 0) ? 5'($urandom) : '0;
            err_rd    = ($urandom_range(0, 9) == 0);
            irq_rd    = ($urandom_range(0, 9) == 0);
            if (k % 200 == 0) begin
                err_enable  = 5'($urandom);
                hold_sel    = 2'($urandom);
                irq_mode_hi = 2'($urandom);
                irq_mode_lo = 2'($urandom);
            end
            @(negedge clk);
        end
        frame_vld = 1'b0; err_rd = 1'b0; irq_rd = 1'b0;
        idle(); idle();
        finish_run();
    end

endmodule